// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address used by a synchronous burst memory across a four-beat burst. When either of two address strobes, one driven by a processor and one by a memory controller, is high at a rising clock edge, the block takes a starting address and clears its burst index. On each later edge where the advance input is high and neither strobe is, the burst index steps by one. The registered address output then shows the next word of the burst.

The burst order is chosen when the address is loaded. In interleaved order the low address bits are the starting low bits XOR the burst index. In linear order they are the starting low bits plus the index, modulo four, so the sequence wraps inside the aligned four-word block. The upper address bits never change during a burst. A single load followed by three advances gives the one-initial-access plus three-single-cycle-beat pattern.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, addrOut is 0 and burstIdx is 0.
- R2: If procStrobe or ctrlStrobe is 1 at a rising edge, then after that edge addrOut equals addrIn as sampled at the edge and burstIdx is 0.
- R3: If advance is 1 and both strobes are 0 at a rising edge, burstIdx increases by one, modulo 4.
- R4: When interleaveIn was 1 at the load, the low two bits of addrOut equal the starting low bits XOR burstIdx. For example, a start of 01 gives 01, 00, 11, 10.
- R5: When interleaveIn was 0 at the load, the low two bits of addrOut equal the starting low bits plus burstIdx, modulo 4. For example, a start of 10 gives 10, 11, 00, 01.
- R6: Bits above the low two bits of addrOut stay equal to the loaded address throughout a burst.
- R7: A fourth advance after a load returns burstIdx to 0 and addrOut to the starting address.
- R8: A strobe at the same edge as advance acts as a load. The advance has no effect.
- R9: With both strobes and advance at 0, addrOut and burstIdx hold. interleaveIn is sampled only at a load, so a change of interleaveIn during a burst does not alter the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| procStrobe | input | 1 | Processor address strobe |
| ctrlStrobe | input | 1 | Controller address strobe |
| advance | input | 1 | Burst advance |
| interleaveIn | input | 1 | Order select at load: 1 interleaved, 0 linear |
| addrIn | input | ADDR_W | Starting address |
| addrOut | output | ADDR_W | Registered current word address |
| burstIdx | output | BURST_W | Current burst index |

## Verification
Every result is due one clock after the edge that samples its stimulus. A load, an advance or a hold shows on addrOut and burstIdx after that single edge, and there is no further pipeline stage. The bench changes inputs on the falling edge and runs its reference model at the rising edge. It compares the outputs two nanoseconds after that rising edge, so every comparison sees the state from exactly one sampled edge. Directed bursts check the literal interleaved and linear sequences, the wrap and the strobe-over-advance priority. A long random run then mixes all input patterns, including mode changes in the middle of a burst.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } ctrl_t;
endpackage

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
  import burst_addr_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               procStrobe,
  input  logic               ctrlStrobe,
  input  logic               advance,
  output ctrl_t              cmd,
  output logic [BURST_W-1:0] burstIdx,
  output logic [BURST_W-1:0] nextIdx
);
  logic [BURST_W-1:0] idxQ;

  always_comb begin
    cmd.load = procStrobe | ctrlStrobe;
    cmd.step = advance & ~cmd.load;
  end

  always_comb begin
    nextIdx = idxQ;
    if (cmd.load)      nextIdx = '0;
    else if (cmd.step) nextIdx = idxQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) idxQ <= '0;
    else       idxQ <= nextIdx;
  end

  assign burstIdx = idxQ;

  p_load_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (procStrobe || ctrlStrobe) |=> (burstIdx == '0));
  p_step_counts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !procStrobe && !ctrlStrobe) |=>
      (burstIdx == BURST_W'($past(burstIdx) + 1'b1)));
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !procStrobe && !ctrlStrobe) |=> $stable(burstIdx));
endmodule

// File: rtl/burst_addr_path.sv
module burst_addr_path
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_t              cmd,
  input  logic [BURST_W-1:0] nextIdx,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               interleaveIn,
  output logic [ADDR_W-1:0]  addrOut
);
  localparam int UPPER_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  baseQ;
  logic               interleaveQ;
  logic [BURST_W-1:0] seqLow;
  logic [ADDR_W-1:0]  addrQ;

  always_comb begin
    if (interleaveQ) seqLow = baseQ[BURST_W-1:0] ^ nextIdx;
    else             seqLow = baseQ[BURST_W-1:0] + nextIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ       <= '0;
      interleaveQ <= 1'b0;
      addrQ       <= '0;
    end else if (cmd.load) begin
      baseQ       <= addrIn;
      interleaveQ <= interleaveIn;
      addrQ       <= addrIn;
    end else if (cmd.step) begin
      addrQ <= {baseQ[ADDR_W-1:BURST_W], seqLow};
    end
  end

  assign addrOut = addrQ;

  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (addrOut == $past(addrIn)));
  p_upper_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.load |=> (addrOut[ADDR_W-1:BURST_W] == $past(addrOut[ADDR_W-1:BURST_W])));
  p_idle_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && !cmd.step) |=> $stable(addrOut));

  if (UPPER_W < 1) begin : g_width_check
    initial $error("ADDR_W must exceed BURST_W");
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W  = 15,
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               procStrobe,
  input  logic               ctrlStrobe,
  input  logic               advance,
  input  logic               interleaveIn,
  input  logic [ADDR_W-1:0]  addrIn,
  output logic [ADDR_W-1:0]  addrOut,
  output logic [BURST_W-1:0] burstIdx
);
  ctrl_t              cmd;
  logic [BURST_W-1:0] nextIdx;

  burst_addr_ctrl #(.BURST_W(BURST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .advance(advance), .cmd(cmd), .burstIdx(burstIdx), .nextIdx(nextIdx)
  );

  burst_addr_path #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) uPath (
    .clk(clk), .rstN(rstN), .cmd(cmd), .nextIdx(nextIdx), .addrIn(addrIn),
    .interleaveIn(interleaveIn), .addrOut(addrOut)
  );
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int AW = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic procStrobe = 1'b0, ctrlStrobe = 1'b0, advance = 1'b0, interleaveIn = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic [1:0]    burstIdx;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [AW-1:0] mBase = '0, mAddr = '0;
  logic [1:0]    mIdx = '0;
  logic          mMode = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq u0 (
    .clk(clk), .rstN(rstN), .procStrobe(procStrobe), .ctrlStrobe(ctrlStrobe),
    .advance(advance), .interleaveIn(interleaveIn), .addrIn(addrIn),
    .addrOut(addrOut), .burstIdx(burstIdx)
  );

  function automatic logic [1:0] expLow(input logic [1:0] s, input logic [1:0] i,
                                        input logic m);
    return m ? (s ^ i) : 2'(s + i);
  endfunction

  task automatic check(input string req, input logic [AW-1:0] a, input logic [1:0] i);
    checks++;
    if (addrOut !== a || burstIdx !== i) begin
      failures++;
      $display("FAIL %s addr=%h idx=%0d expected addr=%h idx=%0d",
               req, addrOut, burstIdx, a, i);
    end
  endtask

  // drive on falling edge, model at rising edge, sample 2 ns later
  task automatic cyc(input logic ps, input logic cs, input logic adv,
                     input logic md, input logic [AW-1:0] a, input string req);
    @(negedge clk);
    procStrobe = ps; ctrlStrobe = cs; advance = adv; interleaveIn = md; addrIn = a;
    @(posedge clk);
    if (ps || cs) begin
      mBase = a; mMode = md; mIdx = 2'd0; mAddr = a;
    end else if (adv) begin
      mIdx = mIdx + 2'd1;
      mAddr = {mBase[AW-1:2], expLow(mBase[1:0], mIdx, mMode)};
    end
    #2;
    check(req, mAddr, mIdx);
  endtask

  task automatic lowIs(input string req, input logic [1:0] v);
    checks++;
    if (addrOut[1:0] !== v) begin
      failures++;
      $display("FAIL %s low=%b expected low=%b", req, addrOut[1:0], v);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog addr=%h expected finish", addrOut);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #2;
    check("R1", '0, 2'd0);
    @(negedge clk); rstN = 1'b1;

    // R4 interleaved, start low 01, processor strobe
    cyc(1, 0, 0, 1, 15'h1235, "R2"); lowIs("R4", 2'b01);
    cyc(0, 0, 1, 1, '0, "R4");       lowIs("R4", 2'b00);
    cyc(0, 0, 1, 1, '0, "R4");       lowIs("R4", 2'b11);
    cyc(0, 0, 1, 1, '0, "R6");       lowIs("R4", 2'b10);
    cyc(0, 0, 1, 1, '0, "R7");       check("R7", 15'h1235, 2'd0);

    // R5 linear, start low 10, controller strobe, mode flips mid burst (R9)
    cyc(0, 1, 0, 0, 15'h4ace, "R2"); lowIs("R5", 2'b10);
    cyc(0, 0, 1, 1, '0, "R9");       lowIs("R5", 2'b11);
    cyc(0, 0, 0, 1, '0, "R9");       lowIs("R9", 2'b11);
    cyc(0, 0, 1, 1, '0, "R5");       lowIs("R5", 2'b00);
    cyc(0, 0, 1, 0, '0, "R3");       lowIs("R5", 2'b01);
    check("R6", 15'h4acd, 2'd3);

    // R8 strobe with advance reloads
    cyc(1, 1, 1, 1, 15'h7ff2, "R8"); check("R8", 15'h7ff2, 2'd0);
    cyc(0, 0, 1, 1, '0, "R3");       check("R3", 15'h7ff3, 2'd1);
    cyc(1, 0, 1, 0, 15'h0003, "R8"); check("R8", 15'h0003, 2'd0);
    cyc(0, 0, 1, 0, '0, "R5");       check("R5", 15'h0000, 2'd1);

    for (int k = 0; k < 600; k++) begin
      logic ps, cs, adv, md;
      logic [AW-1:0] a;
      string req;
      ps  = ($urandom % 6) == 0;
      cs  = ($urandom % 6) == 0;
      adv = ($urandom % 3) != 0;
      md  = $urandom % 2;
      a   = AW'($urandom);
      if (ps || cs) req = adv ? "R8" : "R2";
      else if (adv) req = mMode ? "R4" : "R5";
      else req = "R9";
      cyc(ps, cs, adv, md, a, req);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule